// File: doc/BRIEF.md
# Programmable 24-bit Quadrature Position Counter

This block turns the two phase signals of an incremental encoder into a signed position count. It samples both phases on the system clock and decodes their direction from the phase order. Depending on a rate setting, it counts once, twice or four times per full quadrature cycle. The count is held in a 24-bit register. That register runs either as a plain binary counter or as six packed decimal digits.

A 24-bit preset register serves three purposes. It can be copied into the counter. It is the reload value when divide-by-N operation is chosen. It is the reference for a continuous equality flag. The counter raises one-cycle strobes when it steps past its top value or below zero.

Two active-low control inputs have roles chosen by mode inputs. The first either clears the counter or gates the phase inputs. The second either loads the preset into the counter or snapshots the counter into a 24-bit output latch. All four asynchronous inputs pass through two-flop synchronisers. The mode inputs are treated as static configuration.

Top module: `enc_counter24`

## Requirements
- R1: After reset the count, the output latch and the preset are zero, `carry` and `borrow` are low, and `match` is high.
- R2: The phases are encoded as {quad_a, quad_b}. With `rate` = 2'b1x, every single-phase change counts. The change is +1 along 00→10→11→01→00 (A leads) and −1 along the reverse order. The new count appears 3 clock edges after the input change.
- R3: A sample in which both phases changed at once produces no count.
- R4: With `rate` = 2'b01, only changes of quad_a count, giving two counts per cycle. With `rate` = 2'b00, only the 00→10 (+1) and 10→00 (−1) changes count.
- R5: With `mode_bcd` low, counting up from 0xFFFFFF gives 0 and a one-cycle `carry`. Counting down from 0 gives 0xFFFFFF and a one-cycle `borrow`. `carry` and `borrow` are never high together.
- R6: With `mode_bcd` high, the count steps as six decimal digits. 999999 up gives 000000 with `carry`, and 000000 down gives 999999 with `borrow`.
- R7: With `mode_divn` high, a step that would give a carry or a borrow instead loads the preset into the counter, and still gives the strobe.
- R8: With `ctl_is_enable` low, a low `ctl_n` clears the counter. With `ctl_is_enable` high, steps count only while `ctl_n` is low.
- R9: With `ld_is_latch` low, a low `ld_n` copies the preset into the counter. With `ld_is_latch` high, a low `ld_n` copies the counter into `latch_q` and leaves the counter unchanged.
- R10: `match` is high exactly when the count equals the preset. `preset_wr` writes `preset_in` into the preset.
- R11: When clear and load are both requested, the clear wins. Load wins over a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quad_a | input | 1 | Encoder phase A, asynchronous |
| quad_b | input | 1 | Encoder phase B, asynchronous |
| ctl_n | input | 1 | Active-low clear or phase-enable control |
| ld_n | input | 1 | Active-low load-counter or latch-count control |
| rate | input | 2 | 00 one count per cycle, 01 two, 1x four |
| mode_bcd | input | 1 | High selects six-digit decimal counting |
| mode_divn | input | 1 | High reloads the preset on carry or borrow |
| ctl_is_enable | input | 1 | High makes ctl_n a phase enable, low a clear |
| ld_is_latch | input | 1 | High makes ld_n latch the count, low load the preset |
| preset_wr | input | 1 | Writes preset_in into the preset register |
| preset_in | input | 24 | New preset value |
| count | output | 24 | Current counter value |
| latch_q | output | 24 | Snapshot of the counter |
| carry | output | 1 | One-cycle overflow strobe |
| borrow | output | 1 | One-cycle underflow strobe |
| match | output | 1 | Count equals preset |

## Verification
A faulty phase history or direction decode shows on `count` 3 edges after the offending phase change. It appears either as a step in the wrong direction or as a step that should not have happened, such as one on a double change. A wrong top-of-range or zero detect shows when the count wraps. The strobes then fire at the wrong value, or the count leaves the six-digit decimal range in the same cycle. Misrouted control roles show within a few cycles of the control going low: the counter is cleared, loaded or latched when it should not be.

// File: rtl/enc_counter24.sv
module enc_counter24 #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         quad_a,
  input  logic         quad_b,
  input  logic         ctl_n,
  input  logic         ld_n,
  input  logic [1:0]   rate,
  input  logic         mode_bcd,
  input  logic         mode_divn,
  input  logic         ctl_is_enable,
  input  logic         ld_is_latch,
  input  logic         preset_wr,
  input  logic [W-1:0] preset_in,
  output logic [W-1:0] count,
  output logic [W-1:0] latch_q,
  output logic         carry,
  output logic         borrow,
  output logic         match
);
  localparam int D = W / 4;
  localparam logic [W-1:0] BIN_TOP = '1;
  localparam logic [W-1:0] BCD_TOP = {D{4'h9}};

  logic [3:0] s1, s2;
  logic a_p, b_p;
  logic [W-1:0] count_q, preset_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 4'b0011;
      s2 <= 4'b0011;
      a_p <= 1'b0;
      b_p <= 1'b0;
    end else begin
      s1 <= {quad_a, quad_b, ctl_n, ld_n};
      s2 <= s1;
      a_p <= s2[3];
      b_p <= s2[2];
    end

  wire a_s = s2[3];
  wire b_s = s2[2];
  wire ctl_s = s2[1];
  wire ld_s = s2[0];

  wire a_ch = a_s ^ a_p;
  wire b_ch = b_s ^ b_p;
  wire legal = a_ch ^ b_ch;
  wire up = b_p ^ a_s;
  wire step = legal && (rate[1] ? 1'b1 : rate[0] ? a_ch : (a_ch && !b_s));
  wire cnt_en = step && (ctl_is_enable ? !ctl_s : 1'b1);
  wire clear = !ctl_is_enable && !ctl_s;
  wire load_pre = !ld_is_latch && !ld_s;

  wire at_top = count_q == (mode_bcd ? BCD_TOP : BIN_TOP);
  wire at_zero = count_q == '0;
  wire wrap_up = cnt_en && up && at_top;
  wire wrap_dn = cnt_en && !up && at_zero;

  function automatic logic [W-1:0] bcd_step(input logic [W-1:0] v, input logic inc);
    logic [W-1:0] r;
    logic c;
    logic [3:0] dg;
    r = '0;
    c = 1'b1;
    for (int i = 0; i < D; i++) begin
      dg = v[4*i +: 4];
      if (!c) r[4*i +: 4] = dg;
      else if (inc) begin
        if (dg >= 4'd9) r[4*i +: 4] = 4'd0;
        else begin r[4*i +: 4] = dg + 4'd1; c = 1'b0; end
      end else begin
        if (dg == 4'd0) r[4*i +: 4] = 4'd9;
        else begin r[4*i +: 4] = dg - 4'd1; c = 1'b0; end
      end
    end
    return r;
  endfunction

  wire [W-1:0] nxt = mode_bcd ? bcd_step(count_q, up) :
                     (up ? count_q + 1'b1 : count_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count_q <= '0;
      carry <= 1'b0;
      borrow <= 1'b0;
    end else begin
      carry <= !clear && !load_pre && wrap_up;
      borrow <= !clear && !load_pre && wrap_dn;
      if (clear) count_q <= '0;
      else if (load_pre) count_q <= preset_q;
      else if (cnt_en) count_q <= (mode_divn && (wrap_up || wrap_dn)) ? preset_q : nxt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      preset_q <= '0;
      latch_q <= '0;
    end else begin
      if (preset_wr) preset_q <= preset_in;
      if (ld_is_latch && !ld_s) latch_q <= count_q;
    end

  assign count = count_q;
  assign match = count_q == preset_q;

  // R5
  carry_borrow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry && borrow));

  // R5
  borrow_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    borrow |-> $past(count_q) == '0);

  // R6
  carry_from_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> $past(count_q) == ($past(mode_bcd) ? BCD_TOP : BIN_TOP));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_is_enable && !ctl_s) |=> count_q == '0);

  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_is_enable || ctl_s) && !ld_is_latch && !ld_s) |=> count_q == $past(preset_q));

  // R9
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_is_latch && !ld_s) |=> latch_q == $past(count_q));
endmodule

// File: tb/enc_counter24_tb.sv
module enc_counter24_tb;
  logic clk = 0, rst_n = 0;
  logic qa = 0, qb = 0, ctl_n = 1, ld_n = 1;
  logic [1:0] rate = 2'b10;
  logic mode_bcd = 0, mode_divn = 0, ctl_is_enable = 0, ld_is_latch = 0, preset_wr = 0;
  logic [23:0] preset_in = '0;
  logic [23:0] count, latch_q;
  logic carry, borrow, match;
  int checks = 0, errors = 0, carry_seen = 0, borrow_seen = 0;
  logic [1:0] cur = 2'b00;

  always #5 clk = ~clk;

  enc_counter24 u_dut (.clk, .rst_n, .quad_a(qa), .quad_b(qb), .ctl_n, .ld_n, .rate,
    .mode_bcd, .mode_divn, .ctl_is_enable, .ld_is_latch, .preset_wr, .preset_in,
    .count, .latch_q, .carry, .borrow, .match);

  always @(negedge clk) begin
    if (carry) carry_seen++;
    if (borrow) borrow_seen++;
  end

  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {2'b10, 24'h000001}, {2'b11, 24'h000002}, {2'b01, 24'h000003}, {2'b00, 24'h000004},
    {2'b01, 24'h000003}, {2'b11, 24'h000002}, {2'b10, 24'h000001}, {2'b00, 24'h000000},
    {2'b01, 24'hFFFFFF}, {2'b00, 24'h000000}, {2'b11, 24'h000000}, {2'b00, 24'h000000}};

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] ab);
    cur = ab;
    qa = ab[1];
    qb = ab[0];
    wait_clks(5);
  endtask

  function automatic logic [1:0] nup(input logic [1:0] v);
    case (v)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] ndn(input logic [1:0] v);
    case (v)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic go_up(input int n);
    for (int i = 0; i < n; i++) drive(nup(cur));
  endtask

  task automatic go_dn(input int n);
    for (int i = 0; i < n; i++) drive(ndn(cur));
  endtask

  task automatic set_preset(input logic [23:0] v);
    preset_in = v;
    preset_wr = 1;
    wait_clks(1);
    preset_wr = 0;
    wait_clks(1);
  endtask

  task automatic pulse_ld;
    ld_n = 0;
    wait_clks(5);
    ld_n = 1;
    wait_clks(4);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    wait_clks(3);
    rst_n = 1;
    wait_clks(2);
    // R1
    chk("R1 count", count, 0);
    chk("R1 latch", latch_q, 0);
    chk("R1 strobes", {22'd0, carry, borrow}, 0);
    chk("R1 match", {23'd0, match}, 1);

    // R2 R3 R5: table walk in x4 binary
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25:24]);
      chk($sformatf("R2/R3 vec %0d", i), count, VEC[i][23:0]);
    end
    chk("R5 borrow pulse count", 24'(borrow_seen), 1);
    chk("R5 carry pulse count", 24'(carry_seen), 1);

    // R4 x2 then x1
    rate = 2'b01;
    go_up(4);
    chk("R4 x2 up", count, 2);
    go_dn(4);
    chk("R4 x2 down", count, 0);
    rate = 2'b00;
    go_up(4);
    chk("R4 x1 up", count, 1);
    go_dn(4);
    chk("R4 x1 down", count, 0);
    rate = 2'b10;

    // R6 decimal wrap
    mode_bcd = 1;
    set_preset(24'h999998);
    pulse_ld();
    chk("R9 load preset", count, 24'h999998);
    chk("R10 match equal", {23'd0, match}, 1);
    go_up(1);
    chk("R6 to 999999", count, 24'h999999);
    chk("R10 match unequal", {23'd0, match}, 0);
    carry_seen = 0;
    borrow_seen = 0;
    go_up(1);
    chk("R6 wrap up", count, 0);
    chk("R6 carry", 24'(carry_seen), 1);
    go_dn(1);
    chk("R6 wrap down", count, 24'h999999);
    chk("R6 borrow", 24'(borrow_seen), 1);
    set_preset(24'h000109);
    pulse_ld();
    go_up(1);
    chk("R6 digit carry", count, 24'h000110);

    // R8 clear
    ctl_n = 0;
    wait_clks(5);
    chk("R8 clear", count, 0);
    ctl_n = 1;
    wait_clks(3);

    // R7 divide-by-N
    mode_bcd = 0;
    mode_divn = 1;
    set_preset(24'd2);
    pulse_ld();
    go_dn(2);
    chk("R7 down to zero", count, 0);
    borrow_seen = 0;
    go_dn(1);
    chk("R7 reload on borrow", count, 2);
    chk("R7 borrow strobe", 24'(borrow_seen), 1);
    set_preset(24'd7);
    chk("R10 preset write", {23'd0, match}, 0);
    mode_divn = 0;

    // R8 enable role
    ctl_is_enable = 1;
    go_up(1);
    chk("R8 gated off", count, 2);
    ctl_n = 0;
    wait_clks(4);
    go_up(1);
    chk("R8 gated on", count, 3);

    // R9 latch role
    ld_is_latch = 1;
    pulse_ld();
    chk("R9 latch", latch_q, 3);
    chk("R9 latch keeps count", count, 3);
    go_up(1);
    chk("R9 latch hold", latch_q, 3);
    chk("R9 count moves", count, 4);

    // R11 priority
    ctl_n = 1;
    ctl_is_enable = 0;
    ld_is_latch = 0;
    wait_clks(4);
    ctl_n = 0;
    ld_n = 0;
    wait_clks(5);
    chk("R11 clear over load", count, 0);
    ctl_n = 1;
    wait_clks(5);
    chk("R11 load after clear", count, 7);
    ld_n = 1;
    wait_clks(4);

    summary();
  end
endmodule